// File: doc/BRIEF.md
# Interpolating IF Upconverter

This block turns a baseband sample stream into a stream of unsigned DAC codes at a rate M times higher, with the wanted signal placed on an intermediate frequency. For M = 25, an output rate of 2 MHz and a 700 kHz IF, each input sample arrives at 80 kHz.

Each accepted input sample first goes through a two-tap notch equaliser at the low rate. That stage pre-shapes the spectrum so that the passband of the later resonator comes out flat. The equalised sample then takes the first slot of a group of M high-rate slots. The other M−1 slots carry zero. Every slot is fed through a two-pole integer resonator tuned to the IF. The resonator output is shifted up by half scale and clamped to a 12-bit code.

Both edges of the block are valid/ready streams. The output side may stall at any time. While it stalls, the presented code stays fixed and no filter state changes. The input side is asked for a new sample only when a group of M outputs has started to drain. If no input is offered at that point, the output stream pauses and produces no zeros. Filter state runs on with no reset between blocks of samples (a block is 100 inputs, giving 2500 outputs).

Top module: `upconv_if`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and every filter state register is zero.
- R2: An input is taken on a cycle where in_valid and in_ready are both 1. in_ready is 1 only when a new group of M slots is due and the output register is free (out_valid is 0 or out_ready is 1). It is 0 on the cycle after a sample is taken.
- R3: Each accepted input yields exactly M outputs. When the input is starved at a group boundary, out_valid drops once the last code has been taken, and no further codes appear.
- R4: The equaliser forms e[k] = s[k] + floor(B2·s[k−2] / 1024), with B2 = 1024 − M·(1024 − 1023) = 999 for M = 25. e[k] feeds the first slot of group k.
- R5: The resonator computes y = x − floor(1204·y1 / 1024) − floor(1023·y2 / 1024) in 32-bit two's complement. Here x is e[k] in the first slot of a group and 0 in the other slots.
- R6: out_code = y + 2048, clamped to the range 0..4095.
- R7: While out_valid is 1 and out_ready is 0, out_code holds its value, and the later output sequence is the same as it would be with no stall.
- R8: Filter state carries across 100-sample block boundaries without any reset.
- R9: in_data offered while in_valid is 0 has no effect on any later output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| in_valid | input | 1 | input sample offered |
| in_ready | output | 1 | block takes the offered sample |
| in_data | input | 12 | signed baseband sample |
| out_valid | output | 1 | DAC code present |
| out_ready | input | 1 | consumer takes the code |
| out_code | output | 12 | unsigned DAC code |

## Verification
The hardest situation to reach is a long resonant build-up that is interrupted, either by output stalls or by starving the input at a group boundary. The output must then continue bit-exactly from the same filter state. To get there, the stimulus drives a low-rate tone whose zero-stuffed image falls on the IF, followed by full-scale pseudo-random samples. Pseudo-random out_ready toggling spans the 100-sample block boundary. Idle gaps with garbage on in_data come before the next group. Every code is compared against an arithmetic model of the whole chain that the bench evaluates itself.

// File: rtl/upconv_pkg.sv
package upconv_pkg;
  localparam int UPC_IN_W   = 12;
  localparam int UPC_OUT_W  = 12;
  localparam int UPC_ACC_W  = 32;
  localparam int UPC_SHIFT  = 10;
  localparam int UPC_M      = 25;
  localparam int UPC_A1_MUL = 1204;
  localparam int UPC_A2_MUL = 1023;
endpackage

// File: rtl/upconv_preeq.sv
module upconv_preeq #(
  parameter int IN_W   = 12,
  parameter int ACC_W  = 32,
  parameter int SHIFT  = 10,
  parameter int B2_MUL = 999
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic signed [IN_W-1:0]  din,
  output logic signed [ACC_W-1:0] eq
);
  localparam int MW = ACC_W + 16;

  logic signed [IN_W-1:0] d1, d2;
  logic signed [MW-1:0]   prod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d1 <= '0;
      d2 <= '0;
    end else if (load) begin
      d1 <= din;
      d2 <= d1;
    end
  end

  always_comb begin
    prod = MW'(d2) * MW'(B2_MUL);
    eq   = ACC_W'(din) + ACC_W'(prod >>> SHIFT);
  end

  // two-sample history only moves on a taken sample (R4)
  p_hist_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(d2));
endmodule

// File: rtl/upconv_resonator.sv
module upconv_resonator #(
  parameter int ACC_W  = 32,
  parameter int SHIFT  = 10,
  parameter int A1_MUL = 1204,
  parameter int A2_MUL = 1023
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step,
  input  logic signed [ACC_W-1:0] x,
  output logic signed [ACC_W-1:0] y
);
  localparam int MW = ACC_W + 16;

  logic signed [ACC_W-1:0] y1, y2;
  logic signed [MW-1:0]    p1, p2;

  always_comb begin
    p1 = MW'(y1) * MW'(A1_MUL);
    p2 = MW'(y2) * MW'(A2_MUL);
    y  = x - ACC_W'(p1 >>> SHIFT) - ACC_W'(p2 >>> SHIFT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y1 <= '0;
      y2 <= '0;
    end else if (step) begin
      y1 <= y;
      y2 <= y1;
    end
  end

  // a silent resonator fed with zero stays silent (R5)
  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && x == '0 && y1 == '0 && y2 == '0) |=> (y1 == '0 && y2 == '0));
  // state frozen while no slot is produced (R7)
  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(y1) && $stable(y2)));
endmodule

// File: rtl/upconv_phase.sv
module upconv_phase #(
  parameter int M = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic at_start
);
  localparam int PW = (M > 1) ? $clog2(M) : 1;
  localparam logic [PW-1:0] LAST = PW'(M - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          phase <= '0;
    else if (step)       phase <= (phase == LAST) ? '0 : phase + 1'b1;
  end

  assign at_start = (phase == '0);

  generate
    if (M > 1) begin : g_gap
      // the slot after a data slot is a zero slot (R3)
      p_zero_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && at_start) |=> !at_start);
    end
  endgenerate
endmodule

// File: rtl/upconv_if.sv
module upconv_if
  import upconv_pkg::*;
#(
  parameter int IN_W   = UPC_IN_W,
  parameter int OUT_W  = UPC_OUT_W,
  parameter int ACC_W  = UPC_ACC_W,
  parameter int SHIFT  = UPC_SHIFT,
  parameter int M      = UPC_M,
  parameter int A1_MUL = UPC_A1_MUL,
  parameter int A2_MUL = UPC_A2_MUL
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic signed [IN_W-1:0] in_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [OUT_W-1:0]       out_code
);
  localparam int ONE    = 1 << SHIFT;
  localparam int B2_MUL = ONE - M * (ONE - A2_MUL);
  localparam logic signed [ACC_W:0] MID  = (ACC_W+1)'(1 << (OUT_W - 1));
  localparam logic signed [ACC_W:0] FULL = (ACC_W+1)'((1 << OUT_W) - 1);

  logic                    adv, at_start, step, take;
  logic signed [ACC_W-1:0] eq, x, y;
  logic signed [ACC_W:0]   biased;
  logic [OUT_W-1:0]        code;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv && at_start;
  assign take     = in_valid && in_ready;
  assign step     = adv && (!at_start || in_valid);
  assign x        = at_start ? eq : '0;

  upconv_phase #(.M(M)) phase_i (
    .clk(clk), .rst_n(rst_n), .step(step), .at_start(at_start));

  upconv_preeq #(.IN_W(IN_W), .ACC_W(ACC_W), .SHIFT(SHIFT), .B2_MUL(B2_MUL)) preeq_i (
    .clk(clk), .rst_n(rst_n), .load(take), .din(in_data), .eq(eq));

  upconv_resonator #(.ACC_W(ACC_W), .SHIFT(SHIFT), .A1_MUL(A1_MUL), .A2_MUL(A2_MUL)) reso_i (
    .clk(clk), .rst_n(rst_n), .step(step), .x(x), .y(y));

  always_comb begin
    biased = (ACC_W+1)'(y) + MID;
    if (biased < 0)         code = '0;
    else if (biased > FULL) code = '1;
    else                    code = biased[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_code  <= '0;
    end else if (step) begin
      out_valid <= 1'b1;
      out_code  <= code;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code)));
  p_accept_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);
  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !in_ready);
endmodule

// File: tb/upconv_if_tb.sv
`timescale 1ns/1ps
module upconv_if_tb_top;
  localparam int M = 25;
  localparam int N = 260;
  localparam int NOUT = N * M;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic signed [11:0] in_data = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [11:0]       out_code;

  int checks = 0, fails = 0, idx = 0;
  int stim [N];
  int expv [NOUT];
  bit bp = 0, done = 0, saw_hi = 0, saw_lo = 0;
  int unsigned seed = 32'h1234_5678;

  always #2 clk = ~clk;

  upconv_if dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code));

  function automatic int unsigned lcg(int unsigned s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // arithmetic model of the chain from R4, R5, R6
  task automatic build_model();
    longint s1 = 0, s2 = 0, e, t;
    int y1 = 0, y2 = 0, y;
    for (int k = 0; k < N; k++) begin
      e  = longint'(stim[k]) + ((longint'(999) * s2) >>> 10);
      s2 = s1; s1 = stim[k];
      for (int j = 0; j < M; j++) begin
        t = ((j == 0) ? e : 0) - ((longint'(1204) * y1) >>> 10) - ((longint'(1023) * y2) >>> 10);
        y = int'(t);
        y2 = y1; y1 = y;
        t = longint'(y) + 2048;
        expv[k*M+j] = (t < 0) ? 0 : (t > 4095) ? 4095 : int'(t);
      end
    end
  endtask

  task automatic send(int v);
    bit ok;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 12'(v);
    forever begin
      #1 ok = in_ready;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    @(negedge clk);
    #1 check(!in_ready, "R2 ready after take", in_ready, 0);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) begin
      seed = lcg(seed);
      in_data = seed[27:16];
      @(negedge clk);
    end
    #1 check(!out_valid, "R3 starved output", out_valid, 0);
  endtask

  // out_ready driver
  initial begin
    forever begin
      @(negedge clk);
      if (bp) begin
        seed = lcg(seed);
        out_ready = seed[20];
      end else out_ready = 1'b1;
    end
  end

  // output monitor
  initial begin
    bit pv = 0, pr = 1;
    logic [11:0] pc = '0;
    string tag;
    forever begin
      @(negedge clk);
      #2;
      if (out_valid && pv && !pr)
        check(out_code == pc, "R7 held code", out_code, pc);
      if (out_valid && out_ready) begin
        if (idx >= NOUT) check(0, "R3 extra output", idx, NOUT);
        else begin
          if (expv[idx] == 4095) saw_hi = 1;
          if (expv[idx] == 0) saw_lo = 1;
          if ((idx >= 30*M && idx < 31*M) || (idx >= 150*M && idx < 151*M)) tag = "R9 after gap";
          else if (idx >= 100*M && idx < 101*M) tag = "R8 block boundary";
          else if (expv[idx] == 0 || expv[idx] == 4095) tag = "R6 clamp";
          else if (idx % M == 0) tag = "R4 data slot";
          else tag = "R5 zero slot";
          check(out_code == 12'(expv[idx]), tag, out_code, expv[idx]);
        end
        idx++;
      end
      pv = out_valid; pr = out_ready; pc = out_code;
    end
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", idx, NOUT);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) begin
      if (k == 0) stim[k] = 2047;
      else if (k < 20) stim[k] = 0;
      else if (k < 40) stim[k] = 1500;
      else if (k < 60) stim[k] = (k % 2) ? -2047 : 2047;
      else if (k < 80) stim[k] = (k % 4 == 0) ? 800 : (k % 4 == 2) ? -800 : 0;
      else begin
        seed = lcg(seed);
        stim[k] = int'($signed(seed[27:16]));
      end
    end
    build_model();
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check(!out_valid, "R1 reset valid", out_valid, 0);
    check(in_ready, "R1 reset ready", in_ready, 1);
    rst_n = 1'b1;
    for (int k = 0; k < N; k++) begin
      if (k == 30 || k == 150) idle(3 * M);
      bp = (k >= 90 && k < 200);
      send(stim[k]);
    end
    bp = 0;
    idle(3 * M);
    check(idx == NOUT, "R3 total outputs", idx, NOUT);
    check(saw_hi && saw_lo, "R6 both clamp ends", {saw_hi, saw_lo}, 3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule